// File: doc/BRIEF.md
# Byte-Serial Load/Store Unit

This unit connects a 32-bit processor datapath to a memory that is only one byte wide. The datapath asks for a byte, halfword or word access with a single start strobe. The unit then runs the access as a burst of single-byte transfers, one per clock, at consecutive addresses. Loads are assembled least-significant byte first. Byte and halfword loads are then sign- or zero-extended to the full width. Stores are split into bytes in the same order. Because every transfer moves exactly one byte, an access may begin at any address and needs no alignment check.

Instruction fetch uses the same path as an unsigned full-width load. When the `ALIGN_FETCH` parameter is set, the two low address bits of a fetch are forced to zero. The external memory answers a read with its byte in the same cycle as the request. A write is taken on the clock edge that ends the request cycle.

Top module: `byte_serial_lsu`

## Requirements
- R1: While reset is held and after its release, `done_o`, `mem_req_o` and `mem_we_o` are 0 and `rdata_o` is 0.
- R2: A word access (`size_i` = 2 or 3) makes four byte transfers in four consecutive cycles, at addresses base, base+1, base+2 and base+3.
- R3: A halfword access (`size_i` = 1) makes two byte transfers and a byte access (`size_i` = 0) makes one. No access makes more than four.
- R4: Load bytes are assembled little-endian: the byte read at base+k lands in bits 8k+7..8k of `rdata_o`.
- R5: A byte or halfword load with `signed_i` = 1 copies bit 7 or bit 15, respectively, into all higher bits of `rdata_o`.
- R6: A byte or halfword load with `signed_i` = 0 fills all higher bits of `rdata_o` with zero.
- R7: A store (`write_i` = 1) drives `mem_we_o` only during its transfers and writes bits 8k+7..8k of `wdata_i` to base+k. It writes no address outside the access.
- R8: Misaligned halfword and word accesses behave exactly like aligned ones, with no alignment check.
- R9: `done_o` is high for exactly one cycle, in the cycle right after the last byte transfer.
- R10: `rdata_o` changes only in the cycle where `done_o` rises after a load. After a store it keeps its previous value.
- R11: A start strobe that arrives while an access is in progress is ignored. That access completes unchanged.
- R12: A fetch (`fetch_i` = 1 with the start) is an unsigned word load that ignores `size_i`, `signed_i` and `write_i`. With `ALIGN_FETCH` = 1 its base address has bits 1..0 cleared.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| start_i | input | 1 | Begins an access when the unit is idle |
| fetch_i | input | 1 | Marks the access as an instruction fetch |
| write_i | input | 1 | 1 = store, 0 = load |
| signed_i | input | 1 | Sign-extend byte/halfword loads |
| size_i | input | 2 | 0 byte, 1 halfword, 2 or 3 word |
| addr_i | input | ADDR_W | Base byte address |
| wdata_i | input | DATA_W | Store data |
| rdata_o | output | DATA_W | Load result, held until the next load completes |
| done_o | output | 1 | One-cycle completion pulse |
| mem_req_o | output | 1 | Byte transfer active this cycle |
| mem_we_o | output | 1 | Byte transfer is a write |
| mem_addr_o | output | ADDR_W | Byte address of the current transfer |
| mem_wdata_o | output | 8 | Byte to write |
| mem_rdata_i | input | 8 | Byte read, valid in the request cycle |

## Verification
Each load size is driven against memory bytes chosen so that each requirement shows up in the result. Words with distinct byte values expose any error in byte order. Byte and halfword values with the top bit set make signed and unsigned extension produce different results, while values with the top bit clear catch extension applied on the wrong bit. Misaligned bases are tested for both halfwords and words. Stores are checked by reading the neighbouring RAM bytes, which must be untouched. A second start during a burst, and a fetch presented with conflicting size and sign inputs, show whether stray controls can leak into an access that is already under way.

// File: rtl/lsu_pkg.sv
package lsu_pkg;

    typedef enum logic [1:0] {
        SZ_BYTE = 2'd0,
        SZ_HALF = 2'd1,
        SZ_WORD = 2'd2,
        SZ_WALT = 2'd3
    } acc_size_e;

endpackage

// File: rtl/lsu_byte_pick.sv
module lsu_byte_pick #(
    parameter int DATA_W = 32,
    localparam int NBYTES = DATA_W / 8,
    localparam int CNT_W  = $clog2(NBYTES)
) (
    input  logic [DATA_W-1:0] word_i,
    input  logic [CNT_W-1:0]  idx_i,
    output logic [7:0]        byte_o
);
    always_comb begin
        byte_o = '0;
        for (int j = 0; j < NBYTES; j++) begin
            if (idx_i == CNT_W'(j)) byte_o = word_i[8*j +: 8];
        end
    end
endmodule

// File: rtl/lsu_extend.sv
module lsu_extend #(
    parameter int DATA_W = 32,
    localparam int NBYTES = DATA_W / 8,
    localparam int CNT_W  = $clog2(NBYTES)
) (
    input  logic [DATA_W-1:0] raw_i,
    input  logic [CNT_W-1:0]  top_idx_i,
    input  logic              sgn_i,
    output logic [DATA_W-1:0] ext_o
);
    logic fill_bit;

    always_comb begin
        fill_bit = 1'b0;
        for (int j = 0; j < NBYTES; j++) begin
            if (top_idx_i == CNT_W'(j)) fill_bit = sgn_i & raw_i[8*j+7];
        end
        for (int j = 0; j < NBYTES; j++) begin
            if (CNT_W'(j) <= top_idx_i) ext_o[8*j +: 8] = raw_i[8*j +: 8];
            else                        ext_o[8*j +: 8] = {8{fill_bit}};
        end
    end
endmodule

// File: rtl/byte_serial_lsu.sv
module byte_serial_lsu
    import lsu_pkg::*;
#(
    parameter int ADDR_W      = 32,
    parameter int DATA_W      = 32,
    parameter bit ALIGN_FETCH = 1'b1
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              start_i,
    input  logic              fetch_i,
    input  logic              write_i,
    input  logic              signed_i,
    input  logic [1:0]        size_i,
    input  logic [ADDR_W-1:0] addr_i,
    input  logic [DATA_W-1:0] wdata_i,
    output logic [DATA_W-1:0] rdata_o,
    output logic              done_o,
    output logic              mem_req_o,
    output logic              mem_we_o,
    output logic [ADDR_W-1:0] mem_addr_o,
    output logic [7:0]        mem_wdata_o,
    input  logic [7:0]        mem_rdata_i
);
    localparam int NBYTES = DATA_W / 8;
    localparam int CNT_W  = $clog2(NBYTES);

    typedef struct packed {
        logic              busy;
        logic [CNT_W-1:0]  cnt;
        logic [ADDR_W-1:0] base;
        logic              write;
        logic              sgn;
        acc_size_e         size;
        logic [DATA_W-1:0] wdata;
        logic [DATA_W-1:0] gather;
        logic [DATA_W-1:0] rdata;
        logic              done;
    } lsu_state_t;

    lsu_state_t        st_d, st_q;
    logic [CNT_W-1:0]  top_idx;
    logic [DATA_W-1:0] merged;
    logic [DATA_W-1:0] extended;
    logic [ADDR_W-1:0] start_base;

    always_comb begin
        unique case (st_q.size)
            SZ_BYTE: top_idx = '0;
            SZ_HALF: top_idx = CNT_W'(1);
            default: top_idx = CNT_W'(NBYTES - 1);
        endcase
    end

    always_comb begin
        start_base = addr_i;
        if (ALIGN_FETCH && fetch_i) start_base[CNT_W-1:0] = '0;
    end

    lsu_extend #(.DATA_W(DATA_W)) i_extend (
        .raw_i     (merged),
        .top_idx_i (top_idx),
        .sgn_i     (st_q.sgn),
        .ext_o     (extended)
    );

    lsu_byte_pick #(.DATA_W(DATA_W)) i_pick (
        .word_i (st_q.wdata),
        .idx_i  (st_q.cnt),
        .byte_o (mem_wdata_o)
    );

    always_comb begin
        st_d      = st_q;
        st_d.done = 1'b0;
        merged    = st_q.gather;
        merged[8*st_q.cnt +: 8] = mem_rdata_i;
        if (!st_q.busy) begin
            if (start_i) begin
                st_d.busy   = 1'b1;
                st_d.cnt    = '0;
                st_d.base   = start_base;
                st_d.write  = write_i & ~fetch_i;
                st_d.sgn    = signed_i & ~fetch_i;
                st_d.size   = fetch_i ? SZ_WORD : acc_size_e'(size_i);
                st_d.wdata  = wdata_i;
                st_d.gather = '0;
            end
        end else begin
            if (!st_q.write) st_d.gather = merged;
            if (st_q.cnt == top_idx) begin
                st_d.busy = 1'b0;
                st_d.done = 1'b1;
                if (!st_q.write) st_d.rdata = extended;
            end else begin
                st_d.cnt = st_q.cnt + CNT_W'(1);
            end
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign mem_req_o  = st_q.busy;
    assign mem_we_o   = st_q.busy & st_q.write;
    assign mem_addr_o = st_q.base + ADDR_W'(st_q.cnt);
    assign rdata_o    = st_q.rdata;
    assign done_o     = st_q.done;

endmodule

// File: rtl/lsu_checker.sv
module lsu_checker #(
    parameter int ADDR_W = 32,
    parameter int DATA_W = 32
) (
    input logic              clk,
    input logic              rst_n,
    input logic              mem_req_o,
    input logic              mem_we_o,
    input logic [ADDR_W-1:0] mem_addr_o,
    input logic              done_o,
    input logic [DATA_W-1:0] rdata_o
);
    logic [2:0] run_q;

    always_ff @(posedge clk) begin
        if (!rst_n)         run_q <= '0;
        else if (mem_req_o) run_q <= run_q + 3'd1;
        else                run_q <= '0;
    end

    p_addr_step_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (mem_req_o && $past(mem_req_o)) |-> (mem_addr_o == $past(mem_addr_o) + ADDR_W'(1)));

    p_burst_len_r3: assert property (@(posedge clk) disable iff (!rst_n)
        mem_req_o |-> (run_q < 3'd4));

    p_we_in_req_r7: assert property (@(posedge clk) disable iff (!rst_n)
        mem_we_o |-> mem_req_o);

    p_done_pulse_r9: assert property (@(posedge clk) disable iff (!rst_n)
        done_o |=> !done_o);

    p_done_follows_r9: assert property (@(posedge clk) disable iff (!rst_n)
        done_o |-> (!mem_req_o && $past(mem_req_o)));

    p_rdata_hold_r10: assert property (@(posedge clk) disable iff (!rst_n)
        !done_o |-> $stable(rdata_o));

endmodule

bind byte_serial_lsu lsu_checker #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) i_lsu_checker (
    .clk        (clk),
    .rst_n      (rst_n),
    .mem_req_o  (mem_req_o),
    .mem_we_o   (mem_we_o),
    .mem_addr_o (mem_addr_o),
    .done_o     (done_o),
    .rdata_o    (rdata_o)
);

// File: tb/test_byte_serial_lsu.sv
`timescale 1ns/1ps
module test_byte_serial_lsu;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        start_i = 1'b0, fetch_i = 1'b0, write_i = 1'b0, signed_i = 1'b0;
    logic [1:0]  size_i = '0;
    logic [31:0] addr_i = '0, wdata_i = '0;
    logic [31:0] rdata_o, mem_addr_o;
    logic        done_o, mem_req_o, mem_we_o;
    logic [7:0]  mem_wdata_o, mem_rdata_i;

    logic [7:0]  ram [0:255];
    logic [31:0] log_addr [0:7];
    logic        log_we [0:7];
    int          n_log = 0;
    int          errors = 0, checks = 0, cycles = 0;

    always #10 clk = ~clk;

    byte_serial_lsu i_byte_serial_lsu (
        .clk(clk), .rst_n(rst_n), .start_i(start_i), .fetch_i(fetch_i),
        .write_i(write_i), .signed_i(signed_i), .size_i(size_i),
        .addr_i(addr_i), .wdata_i(wdata_i), .rdata_o(rdata_o), .done_o(done_o),
        .mem_req_o(mem_req_o), .mem_we_o(mem_we_o), .mem_addr_o(mem_addr_o),
        .mem_wdata_o(mem_wdata_o), .mem_rdata_i(mem_rdata_i)
    );

    assign mem_rdata_i = ram[mem_addr_o[7:0]];

    always @(posedge clk) if (mem_req_o && mem_we_o) ram[mem_addr_o[7:0]] <= mem_wdata_o;

    always @(negedge clk) begin
        cycles <= cycles + 1;
        if (mem_req_o && n_log < 8) begin
            log_addr[n_log] <= mem_addr_o;
            log_we[n_log]   <= mem_we_o;
            n_log           <= n_log + 1;
        end
    end

    task automatic check(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s: actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic summary();
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    endtask

    // Runs one access; returns cycles from start edge to done
    task automatic run(input logic [31:0] a, input logic [1:0] sz, input bit sg, input bit wr,
                       input logic [31:0] wd, input bit fe, input bit poke, output int cyc);
        @(negedge clk);
        n_log = 0;
        addr_i = a; size_i = sz; signed_i = sg; write_i = wr; wdata_i = wd; fetch_i = fe;
        start_i = 1'b1;
        @(negedge clk);
        start_i = 1'b0; fetch_i = 1'b0; write_i = 1'b0;
        cyc = 1;
        while (!done_o && cyc < 50) begin
            if (poke && cyc == 2) begin
                addr_i = 32'd100; size_i = 2'd0; write_i = 1'b1; start_i = 1'b1;
            end
            @(negedge clk);
            start_i = 1'b0; write_i = 1'b0;
            cyc++;
        end
    endtask

    task automatic check_bursts(input string req, input logic [31:0] base, input int n, input bit we, input int cyc);
        check(n_log == n, req, n_log, n);
        for (int k = 0; k < n; k++) begin
            check(log_addr[k] == base + k, req, log_addr[k], base + k);
            check(log_we[k] == we, req, {31'd0, log_we[k]}, {31'd0, we});
        end
        check(cyc == n + 1, {req, " done timing R9"}, cyc, n + 1);
    endtask

    task automatic t_reset();
        check(done_o == 1'b0 && mem_req_o == 1'b0 && mem_we_o == 1'b0, "R1", {29'd0, done_o, mem_req_o, mem_we_o}, 0);
        check(rdata_o == 32'd0, "R1", rdata_o, 0);
    endtask

    task automatic t_word_load();
        int c;
        run(32'd16, 2'd2, 1'b0, 1'b0, '0, 1'b0, 1'b0, c);
        check_bursts("R2", 32'd16, 4, 1'b0, c);
        check(rdata_o == 32'h00108093, "R4", rdata_o, 32'h00108093);
        @(negedge clk);
        check(done_o == 1'b0, "R9 pulse", {31'd0, done_o}, 0);
        run(32'd19, 2'd3, 1'b1, 1'b0, '0, 1'b0, 1'b0, c);
        check_bursts("R8", 32'd19, 4, 1'b0, c);
        check(rdata_o == 32'h7FFFF000, "R8", rdata_o, 32'h7FFFF000);
    endtask

    task automatic t_narrow_loads();
        int c;
        run(32'd16, 2'd0, 1'b1, 1'b0, '0, 1'b0, 1'b0, c);
        check_bursts("R3", 32'd16, 1, 1'b0, c);
        check(rdata_o == 32'hFFFFFF93, "R5", rdata_o, 32'hFFFFFF93);
        run(32'd16, 2'd0, 1'b0, 1'b0, '0, 1'b0, 1'b0, c);
        check(rdata_o == 32'h00000093, "R6", rdata_o, 32'h00000093);
        run(32'd20, 2'd1, 1'b1, 1'b0, '0, 1'b0, 1'b0, c);
        check_bursts("R3", 32'd20, 2, 1'b0, c);
        check(rdata_o == 32'hFFFFFFF0, "R5", rdata_o, 32'hFFFFFFF0);
        run(32'd20, 2'd1, 1'b0, 1'b0, '0, 1'b0, 1'b0, c);
        check(rdata_o == 32'h0000FFF0, "R6", rdata_o, 32'h0000FFF0);
        run(32'd21, 2'd1, 1'b1, 1'b0, '0, 1'b0, 1'b0, c);
        check(rdata_o == 32'h00007FFF, "R8 R5", rdata_o, 32'h00007FFF);
        run(32'd22, 2'd0, 1'b1, 1'b0, '0, 1'b0, 1'b0, c);
        check(rdata_o == 32'h0000007F, "R5", rdata_o, 32'h0000007F);
    endtask

    task automatic t_stores();
        int c;
        run(32'd41, 2'd2, 1'b0, 1'b1, 32'hA1B2C3D4, 1'b0, 1'b0, c);
        check_bursts("R7", 32'd41, 4, 1'b1, c);
        check({ram[44], ram[43], ram[42], ram[41]} == 32'hA1B2C3D4, "R7", {ram[44], ram[43], ram[42], ram[41]}, 32'hA1B2C3D4);
        check(ram[40] == 8'h55 && ram[45] == 8'h55, "R7", {16'd0, ram[40], ram[45]}, 32'h5555);
        check(rdata_o == 32'h0000007F, "R10", rdata_o, 32'h0000007F);
        run(32'd51, 2'd1, 1'b0, 1'b1, 32'h11223344, 1'b0, 1'b0, c);
        check_bursts("R7", 32'd51, 2, 1'b1, c);
        check({ram[53], ram[52], ram[51], ram[50]} == 32'h55334455, "R7", {ram[53], ram[52], ram[51], ram[50]}, 32'h55334455);
        run(32'd60, 2'd0, 1'b0, 1'b1, 32'h112233EE, 1'b0, 1'b0, c);
        check({ram[61], ram[60]} == 16'h55EE, "R7", {16'd0, ram[61], ram[60]}, 32'h55EE);
    endtask

    task automatic t_busy_start();
        int c;
        run(32'd16, 2'd2, 1'b0, 1'b0, '0, 1'b0, 1'b1, c);
        check_bursts("R11", 32'd16, 4, 1'b0, c);
        check(rdata_o == 32'h00108093, "R11", rdata_o, 32'h00108093);
        check(ram[100] == 8'h55, "R11", {24'd0, ram[100]}, 32'h55);
        repeat (3) @(negedge clk);
        check(mem_req_o == 1'b0 && rdata_o == 32'h00108093, "R11 R10", rdata_o, 32'h00108093);
    endtask

    task automatic t_fetch();
        int c;
        run(32'd18, 2'd0, 1'b1, 1'b1, 32'hDEADBEEF, 1'b1, 1'b0, c);
        check_bursts("R12", 32'd16, 4, 1'b0, c);
        check(rdata_o == 32'h00108093, "R12", rdata_o, 32'h00108093);
        check(ram[16] == 8'h93, "R12", {24'd0, ram[16]}, 32'h93);
    endtask

    initial begin
        for (int i = 0; i < 256; i++) ram[i] = 8'h55;
        ram[16] = 8'h93; ram[17] = 8'h80; ram[18] = 8'h10; ram[19] = 8'h00;
        ram[20] = 8'hF0; ram[21] = 8'hFF; ram[22] = 8'h7F; ram[23] = 8'h81;
        repeat (3) @(negedge clk);
        t_reset();
        rst_n = 1'b1;
        @(negedge clk);
        t_reset();
        t_word_load();
        t_narrow_loads();
        t_stores();
        t_busy_start();
        t_fetch();
        summary();
    end

    initial begin
        #2000000;
        errors++;
        $display("FAIL watchdog: actual=timeout expected=completion");
        summary();
    end
endmodule